// File: doc/BRIEF.md
# In-DRAM Bulk Row Copy Sequencer

This block sits on the controller side of a DRAM channel. It turns a request to copy one whole row, or to clear one, into the short run of DRAM commands that moves the data inside the memory, so the data never crosses the external bus or the processor caches. Each request names a source and a destination by bank, subarray and row. An initialize flag asks for the destination to be zeroed. A copy always moves a full row, which is 8 KB in the target device.

The sequencer takes one request at a time through a valid/ready handshake. It compares the two locations and picks one of three command recipes. If both rows are in the same subarray, two activates in a row are enough, because the sense amplifiers carry the data from the source row to the destination row. If the rows are in different banks, an internal transfer moves the row between the two banks. If the rows are in different subarrays of one bank, the row is staged through a temporary row in a neighbouring bank. Zero-fill copies from a reserved row that always holds zeros, so each subarray gives up one row to this purpose. Programmable gaps space the commands out. A one-cycle done pulse ends each request.

Top module: `rc_copy_seq`

## Requirements
- R1: While reset is held and in the first cycle after reset, req_ready is 1 and cmd_valid and done are both 0.
- R2: A request is accepted on a rising clock edge where req_valid and req_ready are both 1. req_ready is 1 only when the block is idle. It stays 0 from acceptance until the cycle after the done pulse, so only one request is ever in flight. Request inputs that change after acceptance have no effect.
- R3: If the effective source location (bank, subarray, row) equals the destination, done is 1 in the cycle after acceptance and no command is issued.
- R4: Same bank and same subarray with different rows gives exactly three commands: ACT on the source row, ACT on the destination row, then PRE on that bank. No PRE comes between the two ACTs. Command codes are NOP=0, ACT=1, PRE=2, XFER=3. ACT uses cmd_bank, cmd_sub and cmd_row. PRE uses cmd_bank. XFER moves the open row from bank cmd_bank to bank cmd_peer.
- R5: Different banks gives exactly five commands: ACT on the source, ACT on the destination, XFER from the source bank to the destination bank, PRE on the source bank, PRE on the destination bank.
- R6: Same bank but a different subarray gives exactly eight commands, staged through a temporary row. The temporary row is in bank (source bank + 1) mod NUM_BANKS, subarray TMP_SUB (0), row TMP_ROW (NUM_ROWS-1). The commands are: ACT on the source, ACT on the temporary row, XFER from the source bank to the temporary bank, PRE on the source bank, ACT on the destination, XFER from the temporary bank to the destination bank, PRE on the temporary bank, PRE on the destination bank.
- R7: With req_init set, the source fields are ignored. The source becomes row ZERO_ROW (0) of the destination bank and subarray, and that request then follows R3 or R4.
- R8: After an ACT there are t_ras empty cycles before the next command. After a PRE there are t_rp empty cycles, and after an XFER there are t_xfer empty cycles. A value of 0 means the next command follows in the very next cycle.
- R9: done is high for exactly one cycle, t_rp empty cycles after the final PRE. Every bank that was activated has been precharged by then, and no command appears between done and the next acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request will be taken |
| req_src_bank | input | BANK_W | Source bank |
| req_src_sub | input | SUB_W | Source subarray |
| req_src_row | input | ROW_W | Source row within subarray |
| req_dst_bank | input | BANK_W | Destination bank |
| req_dst_sub | input | SUB_W | Destination subarray |
| req_dst_row | input | ROW_W | Destination row within subarray |
| req_init | input | 1 | Zero the destination instead of copying |
| t_ras | input | TIME_W | Empty cycles after an ACT |
| t_rp | input | TIME_W | Empty cycles after a PRE |
| t_xfer | input | TIME_W | Empty cycles after an XFER |
| cmd_valid | output | 1 | A command is issued this cycle |
| cmd_op | output | 2 | Command code (NOP=0, ACT=1, PRE=2, XFER=3) |
| cmd_bank | output | BANK_W | Target bank, or source bank of an XFER |
| cmd_sub | output | SUB_W | Subarray for ACT |
| cmd_row | output | ROW_W | Row for ACT |
| cmd_peer | output | BANK_W | Destination bank of an XFER |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench sweeps every pairing of source and destination bank and subarray in the default configuration, and varies the three gaps along the way. A wrong step counter or a wrong latched kind shows up as a wrong code or bank on the very next command after the slip. A fault in the gap timer moves the issue cycle of the next command, or of done, by at least one cycle. Because every command is checked against the cycle predicted from the gaps, a single-cycle error is caught at the first command it affects.

// File: rtl/rc_pkg.sv
package rc_pkg;
    typedef enum logic [1:0] {
        OP_NOP  = 2'd0,
        OP_ACT  = 2'd1,
        OP_PRE  = 2'd2,
        OP_XFER = 2'd3
    } rc_op_e;

    typedef enum logic [1:0] {
        KIND_SAME  = 2'd0,
        KIND_INTRA = 2'd1,
        KIND_XBANK = 2'd2,
        KIND_XSUB  = 2'd3
    } rc_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_FIN   = 2'd3
    } rc_state_e;
endpackage

// File: rtl/rc_classify.sv
module rc_classify #(
    parameter int BANK_W   = 2,
    parameter int SUB_W    = 2,
    parameter int ROW_W    = 3,
    parameter int ZERO_ROW = 0
) (
    input  logic [BANK_W-1:0]  src_bank,
    input  logic [SUB_W-1:0]   src_sub,
    input  logic [ROW_W-1:0]   src_row,
    input  logic [BANK_W-1:0]  dst_bank,
    input  logic [SUB_W-1:0]   dst_sub,
    input  logic [ROW_W-1:0]   dst_row,
    input  logic               init,
    output logic [BANK_W-1:0]  eff_bank,
    output logic [SUB_W-1:0]   eff_sub,
    output logic [ROW_W-1:0]   eff_row,
    output rc_pkg::rc_kind_e   kind
);
    import rc_pkg::*;

    // Zero-fill reads from the reserved row of the destination subarray.
    always_comb begin
        eff_bank = init ? dst_bank : src_bank;
        eff_sub  = init ? dst_sub  : src_sub;
        eff_row  = init ? ROW_W'(ZERO_ROW) : src_row;
        if (eff_bank != dst_bank) begin
            kind = KIND_XBANK;
        end else if (eff_sub != dst_sub) begin
            kind = KIND_XSUB;
        end else if (eff_row != dst_row) begin
            kind = KIND_INTRA;
        end else begin
            kind = KIND_SAME;
        end
    end
endmodule

// File: rtl/rc_step_rom.sv
module rc_step_rom #(
    parameter int NUM_BANKS = 4,
    parameter int BANK_W    = 2,
    parameter int SUB_W     = 2,
    parameter int ROW_W     = 3,
    parameter int STEP_W    = 3,
    parameter int TMP_SUB   = 0,
    parameter int TMP_ROW   = 7
) (
    input  rc_pkg::rc_kind_e   kind,
    input  logic [STEP_W-1:0]  step,
    input  logic [BANK_W-1:0]  sb,
    input  logic [SUB_W-1:0]   ss,
    input  logic [ROW_W-1:0]   sr,
    input  logic [BANK_W-1:0]  db,
    input  logic [SUB_W-1:0]   ds,
    input  logic [ROW_W-1:0]   dr,
    output rc_pkg::rc_op_e     op,
    output logic [BANK_W-1:0]  bank,
    output logic [SUB_W-1:0]   sub,
    output logic [ROW_W-1:0]   row,
    output logic [BANK_W-1:0]  peer,
    output logic               last
);
    import rc_pkg::*;

    logic [BANK_W-1:0] tb;
    localparam logic [SUB_W-1:0] TS = SUB_W'(TMP_SUB);
    localparam logic [ROW_W-1:0] TR = ROW_W'(TMP_ROW);

    // Staging bank is the next bank up, wrapping at the top.
    always_comb begin
        tb = (int'(sb) == NUM_BANKS - 1) ? '0 : sb + BANK_W'(1);
    end

    always_comb begin
        op   = OP_NOP;
        bank = '0;
        sub  = '0;
        row  = '0;
        peer = '0;
        last = 1'b0;
        unique case (kind)
            KIND_INTRA: begin
                case (step)
                    3'd0:    begin op = OP_ACT; bank = sb; sub = ss; row = sr; end
                    3'd1:    begin op = OP_ACT; bank = db; sub = ds; row = dr; end
                    default: begin op = OP_PRE; bank = db; last = 1'b1; end
                endcase
            end
            KIND_XBANK: begin
                case (step)
                    3'd0:    begin op = OP_ACT;  bank = sb; sub = ss; row = sr; end
                    3'd1:    begin op = OP_ACT;  bank = db; sub = ds; row = dr; end
                    3'd2:    begin op = OP_XFER; bank = sb; peer = db; end
                    3'd3:    begin op = OP_PRE;  bank = sb; end
                    default: begin op = OP_PRE;  bank = db; last = 1'b1; end
                endcase
            end
            KIND_XSUB: begin
                case (step)
                    3'd0:    begin op = OP_ACT;  bank = sb; sub = ss; row = sr; end
                    3'd1:    begin op = OP_ACT;  bank = tb; sub = TS; row = TR; end
                    3'd2:    begin op = OP_XFER; bank = sb; peer = tb; end
                    3'd3:    begin op = OP_PRE;  bank = sb; end
                    3'd4:    begin op = OP_ACT;  bank = db; sub = ds; row = dr; end
                    3'd5:    begin op = OP_XFER; bank = tb; peer = db; end
                    3'd6:    begin op = OP_PRE;  bank = tb; end
                    default: begin op = OP_PRE;  bank = db; last = 1'b1; end
                endcase
            end
            default: begin
                last = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/rc_gap_timer.sv
module rc_gap_timer #(
    parameter int TIME_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [TIME_W-1:0] load_val,
    output logic              expire
);
    logic [TIME_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - TIME_W'(1);
        end else begin
            cnt_d = '0;
        end
        expire = (cnt_q == TIME_W'(1));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R8
    load_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (cnt_q == '0));
endmodule

// File: rtl/rc_copy_seq.sv
module rc_copy_seq #(
    parameter int NUM_BANKS = 4,
    parameter int NUM_SUBS  = 4,
    parameter int NUM_ROWS  = 8,
    parameter int TIME_W    = 4,
    parameter int ZERO_ROW  = 0,
    parameter int TMP_SUB   = 0,
    parameter int TMP_ROW   = NUM_ROWS - 1,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int SUB_W    = (NUM_SUBS  > 1) ? $clog2(NUM_SUBS)  : 1,
    localparam int ROW_W    = (NUM_ROWS  > 1) ? $clog2(NUM_ROWS)  : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [BANK_W-1:0] req_src_bank,
    input  logic [SUB_W-1:0]  req_src_sub,
    input  logic [ROW_W-1:0]  req_src_row,
    input  logic [BANK_W-1:0] req_dst_bank,
    input  logic [SUB_W-1:0]  req_dst_sub,
    input  logic [ROW_W-1:0]  req_dst_row,
    input  logic              req_init,
    input  logic [TIME_W-1:0] t_ras,
    input  logic [TIME_W-1:0] t_rp,
    input  logic [TIME_W-1:0] t_xfer,
    output logic              cmd_valid,
    output logic [1:0]        cmd_op,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [SUB_W-1:0]  cmd_sub,
    output logic [ROW_W-1:0]  cmd_row,
    output logic [BANK_W-1:0] cmd_peer,
    output logic              done
);
    import rc_pkg::*;

    localparam int STEP_W = 3;

    typedef struct packed {
        rc_state_e         state;
        logic [STEP_W-1:0] step;
        logic              last;
        rc_kind_e          kind;
        logic [BANK_W-1:0] sb;
        logic [SUB_W-1:0]  ss;
        logic [ROW_W-1:0]  sr;
        logic [BANK_W-1:0] db;
        logic [SUB_W-1:0]  ds;
        logic [ROW_W-1:0]  dr;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [BANK_W-1:0] cls_bank;
    logic [SUB_W-1:0]  cls_sub;
    logic [ROW_W-1:0]  cls_row;
    rc_kind_e          cls_kind;

    rc_op_e            rom_op;
    logic [BANK_W-1:0] rom_bank, rom_peer;
    logic [SUB_W-1:0]  rom_sub;
    logic [ROW_W-1:0]  rom_row;
    logic              rom_last;

    logic              tmr_load, tmr_expire;
    logic [TIME_W-1:0] gap;

    rc_classify #(
        .BANK_W(BANK_W), .SUB_W(SUB_W), .ROW_W(ROW_W), .ZERO_ROW(ZERO_ROW)
    ) u_classify (
        .src_bank(req_src_bank), .src_sub(req_src_sub), .src_row(req_src_row),
        .dst_bank(req_dst_bank), .dst_sub(req_dst_sub), .dst_row(req_dst_row),
        .init(req_init),
        .eff_bank(cls_bank), .eff_sub(cls_sub), .eff_row(cls_row),
        .kind(cls_kind)
    );

    rc_step_rom #(
        .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .SUB_W(SUB_W), .ROW_W(ROW_W),
        .STEP_W(STEP_W), .TMP_SUB(TMP_SUB), .TMP_ROW(TMP_ROW)
    ) u_rom (
        .kind(seq_q.kind), .step(seq_q.step),
        .sb(seq_q.sb), .ss(seq_q.ss), .sr(seq_q.sr),
        .db(seq_q.db), .ds(seq_q.ds), .dr(seq_q.dr),
        .op(rom_op), .bank(rom_bank), .sub(rom_sub), .row(rom_row),
        .peer(rom_peer), .last(rom_last)
    );

    rc_gap_timer #(.TIME_W(TIME_W)) u_timer (
        .clk(clk), .rst_n(rst_n),
        .load(tmr_load), .load_val(gap), .expire(tmr_expire)
    );

    // Gap that must follow the command being issued.
    always_comb begin
        case (rom_op)
            OP_ACT:  gap = t_ras;
            OP_PRE:  gap = t_rp;
            OP_XFER: gap = t_xfer;
            default: gap = '0;
        endcase
    end

    always_comb begin
        seq_d    = seq_q;
        tmr_load = 1'b0;
        unique case (seq_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    seq_d.kind = cls_kind;
                    seq_d.sb   = cls_bank;
                    seq_d.ss   = cls_sub;
                    seq_d.sr   = cls_row;
                    seq_d.db   = req_dst_bank;
                    seq_d.ds   = req_dst_sub;
                    seq_d.dr   = req_dst_row;
                    seq_d.step = '0;
                    seq_d.last = 1'b0;
                    seq_d.state = (cls_kind == KIND_SAME) ? ST_FIN : ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                tmr_load   = 1'b1;
                seq_d.last = rom_last;
                if (!rom_last) seq_d.step = seq_q.step + STEP_W'(1);
                if (gap != '0)    seq_d.state = ST_WAIT;
                else if (rom_last) seq_d.state = ST_FIN;
                else               seq_d.state = ST_ISSUE;
            end
            ST_WAIT: begin
                if (tmr_expire) seq_d.state = seq_q.last ? ST_FIN : ST_ISSUE;
            end
            default: begin
                seq_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    always_comb begin
        req_ready = (seq_q.state == ST_IDLE);
        done      = (seq_q.state == ST_FIN);
        cmd_valid = (seq_q.state == ST_ISSUE);
        cmd_op    = cmd_valid ? rom_op : OP_NOP;
        cmd_bank  = cmd_valid ? rom_bank : '0;
        cmd_sub   = cmd_valid ? rom_sub  : '0;
        cmd_row   = cmd_valid ? rom_row  : '0;
        cmd_peer  = cmd_valid ? rom_peer : '0;
    end

    // Open-bank map built from the command port, used only by the checks below.
    logic [NUM_BANKS-1:0] open_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= '0;
        end else if (cmd_valid) begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (int'(cmd_bank) == b) begin
                    if (cmd_op == OP_ACT)      open_q[b] <= 1'b1;
                    else if (cmd_op == OP_PRE) open_q[b] <= 1'b0;
                end
            end
        end
    end

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2
    one_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R9
    all_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (open_q == '0));

    // R4
    pre_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_PRE) |-> open_q[cmd_bank]);

    // R4
    act_reopen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_ACT && open_q[cmd_bank]) |-> (seq_q.kind == KIND_INTRA));

    // R5
    xfer_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_XFER) |-> (open_q[cmd_bank] && open_q[cmd_peer]));
endmodule

// File: tb/tb_rc_copy_seq.sv
module tb_rc_copy_seq;
    localparam int NB = 4, NS = 4, NR = 8, TW = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_init = 1'b0;
    logic [1:0] req_src_bank = '0, req_dst_bank = '0, req_src_sub = '0, req_dst_sub = '0;
    logic [2:0] req_src_row = '0, req_dst_row = '0;
    logic [TW-1:0] t_ras = '0, t_rp = '0, t_xfer = '0;
    logic req_ready, cmd_valid, done;
    logic [1:0] cmd_op, cmd_bank, cmd_sub, cmd_peer;
    logic [2:0] cmd_row;

    rc_copy_seq dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_src_bank(req_src_bank), .req_src_sub(req_src_sub), .req_src_row(req_src_row),
        .req_dst_bank(req_dst_bank), .req_dst_sub(req_dst_sub), .req_dst_row(req_dst_row),
        .req_init(req_init), .t_ras(t_ras), .t_rp(t_rp), .t_xfer(t_xfer),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_bank(cmd_bank), .cmd_sub(cmd_sub),
        .cmd_row(cmd_row), .cmd_peer(cmd_peer), .done(done)
    );

    always #4 clk = ~clk;

    int errors = 0, checks = 0, cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int lg_op[32], lg_bank[32], lg_sub[32], lg_row[32], lg_peer[32], lg_cyc[32];
    int lg_n = 0, done_cyc = 0, ready_hi = 0, stray = 0;
    bit logging = 1'b0;

    always @(negedge clk) begin
        if (logging) begin
            if (req_ready) ready_hi++;
            if (cmd_valid && lg_n < 32) begin
                lg_op[lg_n] = int'(cmd_op);   lg_bank[lg_n] = int'(cmd_bank);
                lg_sub[lg_n] = int'(cmd_sub); lg_row[lg_n] = int'(cmd_row);
                lg_peer[lg_n] = int'(cmd_peer); lg_cyc[lg_n] = cyc;
                lg_n++;
            end
            if (done) begin
                done_cyc = cyc;
                logging = 1'b0;
            end
        end else if (rst_n && (cmd_valid || done)) begin
            stray++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    int e_op[8], e_bank[8], e_sub[8], e_row[8], e_peer[8], e_n;

    task automatic add(input int op, input int b, input int s, input int r, input int p);
        e_op[e_n] = op; e_bank[e_n] = b; e_sub[e_n] = s; e_row[e_n] = r; e_peer[e_n] = p;
        e_n++;
    endtask

    task automatic run(input int sb, input int ss, input int sr, input int db, input int ds,
                       input int dr, input bit init, input int tr, input int tp, input int tx);
        int esb, ess, esr, tb_, acc, off, w, g;
        string tag;
        esb = init ? db : sb; ess = init ? ds : ss; esr = init ? 0 : sr;
        tb_ = (esb + 1) % NB;
        e_n = 0;
        if (esb != db) begin
            tag = "R5";
            add(1, esb, ess, esr, 0); add(1, db, ds, dr, 0);
            add(3, esb, 0, 0, db); add(2, esb, 0, 0, 0); add(2, db, 0, 0, 0);
        end else if (ess != ds) begin
            tag = "R6";
            add(1, esb, ess, esr, 0); add(1, tb_, 0, NR - 1, 0);
            add(3, esb, 0, 0, tb_); add(2, esb, 0, 0, 0);
            add(1, db, ds, dr, 0); add(3, tb_, 0, 0, db);
            add(2, tb_, 0, 0, 0); add(2, db, 0, 0, 0);
        end else if (esr != dr) begin
            tag = "R4";
            add(1, esb, ess, esr, 0); add(1, db, ds, dr, 0); add(2, db, 0, 0, 0);
        end else begin
            tag = "R3";
        end
        if (init) tag = {tag, "/R7"};

        @(negedge clk);
        t_ras = TW'(tr); t_rp = TW'(tp); t_xfer = TW'(tx);
        req_src_bank = 2'(sb); req_src_sub = 2'(ss); req_src_row = 3'(sr);
        req_dst_bank = 2'(db); req_dst_sub = 2'(ds); req_dst_row = 3'(dr);
        req_init = init; req_valid = 1'b1;
        chk(req_ready == 1'b1, "R2 ready when idle", int'(req_ready), 1);
        lg_n = 0; ready_hi = 0; done_cyc = -1;
        @(posedge clk);
        #1;
        acc = cyc; logging = 1'b1; req_valid = 1'b0;
        req_src_bank = ~req_src_bank; req_dst_row = ~req_dst_row;
        req_dst_sub = ~req_dst_sub;  req_init = ~req_init;
        w = 0;
        while (logging && w < 300) begin
            @(posedge clk);
            w++;
        end
        if (logging) begin
            logging = 1'b0;
            chk(1'b0, "R9 timeout waiting for done", w, 0);
        end
        chk(lg_n == e_n, {tag, " command count"}, lg_n, e_n);
        off = 0;
        for (int i = 0; i < e_n && i < lg_n; i++) begin
            chk(lg_op[i] == e_op[i], {tag, " op"}, lg_op[i], e_op[i]);
            chk(lg_bank[i] == e_bank[i], {tag, " bank"}, lg_bank[i], e_bank[i]);
            if (e_op[i] == 1) begin
                chk(lg_sub[i] == e_sub[i], {tag, " subarray"}, lg_sub[i], e_sub[i]);
                chk(lg_row[i] == e_row[i], {tag, " row"}, lg_row[i], e_row[i]);
            end
            if (e_op[i] == 3) chk(lg_peer[i] == e_peer[i], {tag, " xfer peer"}, lg_peer[i], e_peer[i]);
            chk(lg_cyc[i] == acc + off, "R8 command cycle", lg_cyc[i] - acc, off);
            g = (e_op[i] == 1) ? tr : (e_op[i] == 2) ? tp : tx;
            off += g + 1;
        end
        chk(done_cyc == acc + off, "R9 done cycle", done_cyc - acc, off);
        chk(ready_hi == 0, "R2 ready low while busy", ready_hi, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1 && cmd_valid == 1'b0 && done == 1'b0, "R1 in reset",
            {req_ready, cmd_valid, done}, 3'b100);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && cmd_valid == 1'b0 && done == 1'b0, "R1 after reset",
            {req_ready, cmd_valid, done}, 3'b100);

        // R3 same location, R7 init onto reserved row is also a no-op
        run(1, 2, 5, 1, 2, 5, 1'b0, 2, 1, 1);
        run(3, 1, 4, 2, 3, 0, 1'b1, 1, 1, 1);
        // R4 with zero gaps, R6 with wrapping staging bank
        run(0, 0, 1, 0, 0, 6, 1'b0, 0, 0, 0);
        run(3, 0, 2, 3, 2, 5, 1'b0, 3, 2, 1);
        // R7 zero-fill to a normal row
        run(0, 0, 0, 2, 1, 3, 1'b1, 2, 2, 2);

        for (int i = 0; i < 256; i++) begin
            run(i % 4, (i / 4) % 4, (i * 3 + 1) % NR, (i / 16) % 4, (i / 64) % 4,
                (i * 5 + 2) % NR, (i % 7) == 3, i % 4, (i / 3) % 3, (i / 5) % 3);
        end

        repeat (5) @(negedge clk);
        chk(stray == 0, "R9 no command outside a request", stray, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule